// File: doc/BRIEF.md
# Synchronous Capture Burst Reader

This block sits between a trigger source and a serial register-read engine for a combined accelerometer and gyroscope sensor. When a trigger pulse arrives while the block is idle, it samples a free-running time base and latches a 7-bit mask of enabled channels. It then reads one register per enabled channel from the sensor's capture bank, one request at a time.

Only the first read of a burst raises the capture flag. That flag makes the sensor freeze every axis at one instant. The reads that follow fetch those frozen values, so acceleration and angular rate in one packet describe the same moment. The signed 16-bit results are packed into consecutive slots and presented as one packet together with the trigger-time stamp. If any read fails, the burst is dropped silently. A trigger that arrives while a burst is running is discarded and counted.

Top module: `capture_burst_reader`

## Requirements
- R1: Channel index n (temperature 0, acceleration X/Y/Z 1 to 3, angular rate X/Y/Z 4 to 6) is read from register address 0x17 + n. Only enabled channels are requested.
- R2: Within one burst, the enabled channels are requested in strictly ascending index order.
- R3: `rd_cap_o` is 1 on the first request of a burst and 0 on every later request of that burst.
- R4: The packet carries the k-th returned sample in slot k (bits 16k+15 down to 16k of `pkt_data_o`). Slots above the sample count read as zero. `pkt_cnt_o` equals the number of enabled channels.
- R5: A read completed with `rd_err_i` high ends the burst. No further request is issued, no packet is emitted, and the block returns to idle.
- R6: `pkt_ts_o` holds the value `time_i` had at the clock edge where the trigger was accepted, not the value at completion.
- R7: A trigger seen while a burst is in progress (busy) starts nothing, leaves the running burst unchanged, and increments `ovr_cnt_o` by one. The counter saturates.
- R8: A trigger with an all-zero mask issues no request. One cycle after acceptance it emits a packet with count 0 and the trigger timestamp.
- R9: After reset, `rd_req_o`, `pkt_valid_o` and `busy_o` are 0 and `ovr_cnt_o` is 0.
- R10: At most one read is outstanding. No request is issued between a request and its `rd_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Capture trigger pulse |
| chan_en_i | input | 7 | Channel enable mask, bit n enables channel n |
| time_i | input | TS_W | Free-running time base |
| rd_req_o | output | 1 | One-cycle read request to the register engine |
| rd_addr_o | output | 8 | Register address of the request |
| rd_cap_o | output | 1 | Capture flag carried with the request |
| rd_done_i | input | 1 | Read completion strobe |
| rd_data_i | input | 16 | Read data, valid with `rd_done_i` |
| rd_err_i | input | 1 | Read failed, valid with `rd_done_i` |
| pkt_valid_o | output | 1 | One-cycle packet strobe |
| pkt_cnt_o | output | 3 | Number of samples in the packet |
| pkt_data_o | output | 112 | Packed samples, slot k at bits 16k+15:16k |
| pkt_ts_o | output | TS_W | Timestamp taken at the trigger |
| busy_o | output | 1 | A burst is in progress |
| ovr_cnt_o | output | OVR_W | Saturating count of dropped triggers |

## Verification
The assertions check the request side on every cycle:
- Addresses stay inside the capture bank and rise within a burst.
- The capture flag appears only on the first request.
- Only one read is outstanding at a time, and nothing follows a failed read.
- An emitted packet's count matches the good completions.
- Idle cycles never move the overrun counter.

Only the bench scenarios can show the rest:
- The packed sample values and their slot positions.
- That the timestamp comes from the trigger cycle.
- That aborted bursts emit nothing and a burst with no enabled channels emits an empty packet.
- The exact overrun totals after triggers dropped in mid-burst.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int unsigned CH_NUM   = 7;
    localparam int unsigned SAMPLE_W = 16;
    localparam int unsigned REG_AW   = 8;
    localparam int unsigned CH_IDX_W = $clog2(CH_NUM);
    localparam int unsigned CNT_W    = $clog2(CH_NUM + 1);
    localparam int unsigned PKT_W    = CH_NUM * SAMPLE_W;
    localparam logic [REG_AW-1:0] CAP_BASE = 8'h17;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_EMIT
    } burst_state_e;

    typedef struct packed {
        logic                valid;
        logic [CH_IDX_W-1:0] idx;
    } chan_pick_t;

    // Lowest set bit of the pending mask wins.
    function automatic chan_pick_t pick_lowest(input logic [CH_NUM-1:0] m);
        chan_pick_t p;
        p = '0;
        for (int i = CH_NUM - 1; i >= 0; i--) begin
            if (m[i]) begin
                p.valid = 1'b1;
                p.idx   = CH_IDX_W'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/sbr_chan_pick.sv
module sbr_chan_pick
    import sbr_pkg::*;
(
    input  logic [CH_NUM-1:0] pend_i,
    output chan_pick_t        pick_o,
    output logic [CH_NUM-1:0] onehot_o
);
    always_comb pick_o = pick_lowest(pend_i);

    for (genvar g = 0; g < CH_NUM; g++) begin : g_onehot
        assign onehot_o[g] = pick_o.valid && (pick_o.idx == CH_IDX_W'(g));
    end
endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
    import sbr_pkg::*;
#(
    parameter int unsigned TS_W  = 32,
    parameter int unsigned OVR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [CH_NUM-1:0] chan_en_i,
    input  logic [TS_W-1:0]   time_i,
    input  logic              rd_done_i,
    input  logic              rd_err_i,
    input  chan_pick_t        pick_i,
    input  logic [CH_NUM-1:0] onehot_i,
    output logic [CH_NUM-1:0] pend_o,
    output logic              rd_req_o,
    output logic [REG_AW-1:0] rd_addr_o,
    output logic              rd_cap_o,
    output logic              start_o,
    output logic              store_o,
    output logic              emit_o,
    output logic              busy_o,
    output logic [TS_W-1:0]   ts_o,
    output logic [OVR_W-1:0]  ovr_o
);
    burst_state_e      state_q;
    logic [CH_NUM-1:0] mask_q;
    logic              first_q;
    logic [TS_W-1:0]   ts_q;
    logic [OVR_W-1:0]  ovr_q;

    always_comb begin
        pend_o    = mask_q;
        busy_o    = (state_q != ST_IDLE);
        rd_req_o  = (state_q == ST_ISSUE) && pick_i.valid;
        rd_addr_o = CAP_BASE + REG_AW'(pick_i.idx);
        rd_cap_o  = rd_req_o && first_q;
        start_o   = (state_q == ST_IDLE) && trig_i;
        store_o   = (state_q == ST_WAIT) && rd_done_i && !rd_err_i;
        emit_o    = (state_q == ST_EMIT);
        ts_o      = ts_q;
        ovr_o     = ovr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            first_q <= 1'b0;
            ts_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (trig_i) begin
                        mask_q  <= chan_en_i;
                        ts_q    <= time_i;
                        first_q <= 1'b1;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (pick_i.valid) begin
                        mask_q  <= mask_q & ~onehot_i;
                        first_q <= 1'b0;
                        state_q <= ST_WAIT;
                    end else begin
                        state_q <= ST_EMIT;
                    end
                end
                ST_WAIT: begin
                    if (rd_done_i) begin
                        state_q <= rd_err_i ? ST_IDLE : ST_ISSUE;
                    end
                end
                ST_EMIT: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= '0;
        end else if (trig_i && (state_q != ST_IDLE) && (ovr_q != {OVR_W{1'b1}})) begin
            ovr_q <= ovr_q + 1'b1;
        end
    end
endmodule

// File: rtl/sbr_packer.sv
module sbr_packer
    import sbr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                store_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [PKT_W-1:0]    data_o,
    output logic [CNT_W-1:0]    cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            cnt_q <= '0;
        end else if (store_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar g = 0; g < CH_NUM; g++) begin : g_slot
        logic [SAMPLE_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst || start_i) begin
                slot_q <= '0;
            end else if (store_i && (cnt_q == CNT_W'(g))) begin
                slot_q <= sample_i;
            end
        end
        assign data_o[g*SAMPLE_W +: SAMPLE_W] = slot_q;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/capture_burst_reader.sv
module capture_burst_reader
    import sbr_pkg::*;
#(
    parameter int unsigned TS_W  = 32,
    parameter int unsigned OVR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig_i,
    input  logic [CH_NUM-1:0]   chan_en_i,
    input  logic [TS_W-1:0]     time_i,
    output logic                rd_req_o,
    output logic [REG_AW-1:0]   rd_addr_o,
    output logic                rd_cap_o,
    input  logic                rd_done_i,
    input  logic [SAMPLE_W-1:0] rd_data_i,
    input  logic                rd_err_i,
    output logic                pkt_valid_o,
    output logic [CNT_W-1:0]    pkt_cnt_o,
    output logic [PKT_W-1:0]    pkt_data_o,
    output logic [TS_W-1:0]     pkt_ts_o,
    output logic                busy_o,
    output logic [OVR_W-1:0]    ovr_cnt_o
);
    chan_pick_t        pick;
    logic [CH_NUM-1:0] onehot;
    logic [CH_NUM-1:0] pend;
    logic              start;
    logic              store;

    sbr_chan_pick u_pick (
        .pend_i   (pend),
        .pick_o   (pick),
        .onehot_o (onehot)
    );

    sbr_ctrl #(.TS_W(TS_W), .OVR_W(OVR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (trig_i),
        .chan_en_i (chan_en_i),
        .time_i    (time_i),
        .rd_done_i (rd_done_i),
        .rd_err_i  (rd_err_i),
        .pick_i    (pick),
        .onehot_i  (onehot),
        .pend_o    (pend),
        .rd_req_o  (rd_req_o),
        .rd_addr_o (rd_addr_o),
        .rd_cap_o  (rd_cap_o),
        .start_o   (start),
        .store_o   (store),
        .emit_o    (pkt_valid_o),
        .busy_o    (busy_o),
        .ts_o      (pkt_ts_o),
        .ovr_o     (ovr_cnt_o)
    );

    sbr_packer u_pack (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .store_i  (store),
        .sample_i (rd_data_i),
        .data_o   (pkt_data_o),
        .cnt_o    (pkt_cnt_o)
    );
endmodule

// File: rtl/capture_burst_reader_chk.sv
module capture_burst_reader_chk
    import sbr_pkg::*;
#(
    parameter int unsigned OVR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              rd_req_o,
    input logic [REG_AW-1:0] rd_addr_o,
    input logic              rd_cap_o,
    input logic              rd_done_i,
    input logic              rd_err_i,
    input logic              pkt_valid_o,
    input logic [CNT_W-1:0]  pkt_cnt_o,
    input logic [OVR_W-1:0]  ovr_cnt_o
);
    logic              out_q;
    logic              seen_q;
    logic              err_q;
    logic [REG_AW-1:0] last_q;
    logic [CNT_W-1:0]  good_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
        end else if (rd_req_o) begin
            out_q <= 1'b1;
        end else if (rd_done_i) begin
            out_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !busy_o) begin
            seen_q <= 1'b0;
            err_q  <= 1'b0;
            last_q <= '0;
            good_q <= '0;
        end else begin
            if (rd_req_o) begin
                seen_q <= 1'b1;
                last_q <= rd_addr_o;
            end
            if (rd_done_i && rd_err_i) err_q <= 1'b1;
            if (rd_done_i && !rd_err_i) good_q <= good_q + 1'b1;
        end
    end

    AST_ADDR_IN_BANK: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> (rd_addr_o >= CAP_BASE) && (rd_addr_o < REG_AW'(CAP_BASE + CH_NUM))); // R1
    AST_ADDR_RISING: assert property (@(posedge clk) disable iff (rst)
        rd_req_o && seen_q |-> rd_addr_o > last_q); // R2
    AST_CAP_ON_FIRST: assert property (@(posedge clk) disable iff (rst)
        rd_req_o && !seen_q |-> rd_cap_o); // R3
    AST_CAP_OFF_LATER: assert property (@(posedge clk) disable iff (rst)
        rd_req_o && seen_q |-> !rd_cap_o); // R3
    AST_PKT_COUNT: assert property (@(posedge clk) disable iff (rst)
        pkt_valid_o |-> pkt_cnt_o == good_q); // R4
    AST_NO_PKT_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
        pkt_valid_o |-> !err_q); // R5
    AST_NO_REQ_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> !err_q); // R5
    AST_IDLE_OVR_STILL: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> ovr_cnt_o == $past(ovr_cnt_o)); // R7
    AST_EMPTY_NO_TRAFFIC: assert property (@(posedge clk) disable iff (rst)
        pkt_valid_o && (pkt_cnt_o == '0) |-> !seen_q); // R8
    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> !out_q); // R10
endmodule

bind capture_burst_reader capture_burst_reader_chk #(.OVR_W(OVR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy_o      (busy_o),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_cap_o    (rd_cap_o),
    .rd_done_i   (rd_done_i),
    .rd_err_i    (rd_err_i),
    .pkt_valid_o (pkt_valid_o),
    .pkt_cnt_o   (pkt_cnt_o),
    .ovr_cnt_o   (ovr_cnt_o)
);

// File: tb/tb_capture_burst_reader.sv
`timescale 1ns/1ps
module tb_capture_burst_reader;
    import sbr_pkg::*;

    localparam int TS_W  = 32;
    localparam int OVR_W = 8;
    localparam int LAT   = 2;

    logic                clk = 1'b0;
    logic                rst;
    logic                trig;
    logic [CH_NUM-1:0]   chan_en;
    logic [TS_W-1:0]     tcount = '0;
    logic                rd_req;
    logic [REG_AW-1:0]   rd_addr;
    logic                rd_cap;
    logic                rd_done = 1'b0;
    logic [SAMPLE_W-1:0] rd_data = '0;
    logic                rd_err = 1'b0;
    logic                pkt_valid;
    logic [CNT_W-1:0]    pkt_cnt;
    logic [PKT_W-1:0]    pkt_data;
    logic [TS_W-1:0]     pkt_ts;
    logic                busy;
    logic [OVR_W-1:0]    ovr_cnt;

    always #2.5 clk = ~clk;
    always @(posedge clk) tcount <= tcount + 1'b1;

    capture_burst_reader #(.TS_W(TS_W), .OVR_W(OVR_W)) dut (
        .clk (clk), .rst (rst), .trig_i (trig), .chan_en_i (chan_en), .time_i (tcount),
        .rd_req_o (rd_req), .rd_addr_o (rd_addr), .rd_cap_o (rd_cap),
        .rd_done_i (rd_done), .rd_data_i (rd_data), .rd_err_i (rd_err),
        .pkt_valid_o (pkt_valid), .pkt_cnt_o (pkt_cnt), .pkt_data_o (pkt_data),
        .pkt_ts_o (pkt_ts), .busy_o (busy), .ovr_cnt_o (ovr_cnt)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard queues filled by the driver
    logic [8:0]       exp_req_q[$];
    logic [PKT_W-1:0] exp_data_q[$];
    int               exp_cnt_q[$];
    logic [TS_W-1:0]  exp_ts_q[$];

    // Register engine model state
    int                  lat_ctr = 0;
    int                  req_no = 0;
    int                  err_at = -1;
    logic [7:0]          burst_tag = '0;
    logic [SAMPLE_W-1:0] resp_data = '0;
    logic                resp_err = 1'b0;

    // Engine model and monitor, both at the falling edge
    always @(negedge clk) begin
        rd_done = 1'b0;
        rd_err  = 1'b0;
        if (lat_ctr > 0) begin
            lat_ctr--;
            if (lat_ctr == 0) begin
                rd_done = 1'b1;
                rd_data = resp_data;
                rd_err  = resp_err;
            end
        end
        if (!rst && rd_req) begin
            check("R10", "request while a read is outstanding",
                  128'((lat_ctr > 0) || rd_done), 128'(0));
            if (exp_req_q.size() == 0) begin
                check("R1", "unexpected request address", 128'(rd_addr), 128'hFFFF);
            end else begin
                logic [8:0] e;
                e = exp_req_q.pop_front();
                check("R1/R2", "request address", 128'(rd_addr), 128'(e[7:0]));
                check("R3", "capture flag", 128'(rd_cap), 128'(e[8]));
            end
            resp_data = {burst_tag ^ 8'h96, rd_addr};
            resp_err  = (req_no == err_at);
            req_no++;
            lat_ctr = LAT;
        end
        if (!rst && pkt_valid) begin
            if (exp_cnt_q.size() == 0) begin
                check("R5", "unexpected packet count", 128'(pkt_cnt), 128'hFFFF);
            end else begin
                int c;
                c = exp_cnt_q.pop_front();
                check(c == 0 ? "R8" : "R4", "packet count", 128'(pkt_cnt), 128'(c));
                check("R4", "packet data", 128'(pkt_data), 128'(exp_data_q.pop_front()));
                check("R6", "packet timestamp", 128'(pkt_ts), 128'(exp_ts_q.pop_front()));
            end
        end
    end

    // Driver: predicts requests and packet, then fires the trigger
    task automatic run_burst(input logic [CH_NUM-1:0] mask, input int err_k, input int extra);
        logic [PKT_W-1:0] d;
        int  n;
        bit  first;
        d = '0;
        n = 0;
        first = 1'b1;
        burst_tag = burst_tag + 1'b1;
        req_no = 0;
        err_at = err_k;
        for (int i = 0; i < CH_NUM; i++) begin
            if (mask[i]) begin
                if (err_k < 0 || n <= err_k) exp_req_q.push_back({first, CAP_BASE + 8'(i)});
                first = 1'b0;
                d[n*SAMPLE_W +: SAMPLE_W] = {burst_tag ^ 8'h96, CAP_BASE + 8'(i)};
                n++;
            end
        end
        if (err_k < 0) begin
            exp_data_q.push_back(d);
            exp_cnt_q.push_back(n);
            exp_ts_q.push_back(tcount);
        end
        chan_en = mask;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chan_en = ~mask;
        for (int k = 0; k < extra; k++) begin
            repeat (3) @(negedge clk);
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
        end
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        rst = 1'b1;
        trig = 1'b0;
        chan_en = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check("R9", "request after reset", 128'(rd_req), 128'(0));
        check("R9", "packet strobe after reset", 128'(pkt_valid), 128'(0));
        check("R9", "busy after reset", 128'(busy), 128'(0));
        check("R9", "overrun count after reset", 128'(ovr_cnt), 128'(0));
        repeat (2) @(negedge clk);

        run_burst(7'h7F, -1, 0);          // R1 R2 R3 R4 R6: all channels
        run_burst(7'b1010010, -1, 0);     // sparse mask
        run_burst(7'b1000000, -1, 0);     // only the highest channel
        run_burst(7'b0000001, -1, 0);     // only temperature
        run_burst(7'h00, -1, 0);          // R8: empty mask
        run_burst(7'h7F, 2, 0);           // R5: third read fails
        check("R5", "busy after abort", 128'(busy), 128'(0));
        run_burst(7'b0000110, 0, 0);      // R5: first read fails
        run_burst(7'b0001110, -1, 0);     // recovery after abort
        check("R7", "overrun count before drops", 128'(ovr_cnt), 128'(0));
        run_burst(7'h7F, -1, 1);          // R7: one dropped trigger
        check("R7", "overrun count after one drop", 128'(ovr_cnt), 128'(1));
        run_burst(7'b0110011, -1, 2);     // R7: two more dropped
        check("R7", "overrun count after three drops", 128'(ovr_cnt), 128'(3));

        check("R1", "requests left unissued", 128'(exp_req_q.size()), 128'(0));
        check("R4", "packets left unemitted", 128'(exp_cnt_q.size()), 128'(0));
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired: actual hung, expected completion");
            summary();
            $finish;
        end
    end
endmodule